// File: doc/BRIEF.md
# Virtual-Cycle Neighbour Barrier Controller

This block paces one tile of a multi-board emulator of a mesh-connected many-core target. The target's own flip-flops are updated only when a single enable is high. Many fast system clocks make up one target clock, called a virtual cycle. At the start of each virtual cycle the controller tells the serial link senders to transmit this tile's synchronisation data to its adjacent tiles. It then waits for three things:

- every link to report that its transmission is done;
- data to arrive from every adjacent tile;
- the local memory multiplexer to report that this cycle's accesses are finished.

When all of these have been seen, it raises the target enable for one clock and starts the next virtual cycle.

Only the four direct neighbours take part in the barrier. The synchronisation cost per virtual cycle therefore stays the same no matter how large the mesh is. A presence mask tells the controller which directions have a neighbour, so tiles on the edges and corners of the mesh skip the missing links. A free-running count of completed virtual cycles is provided for speed measurement.

Top module: `vcyc_barrier_ctrl`

## Requirements
- R1: While `rst_n` is low, `tgt_en`, `tx_start` and `vcyc_count` are all zero. In the first clock after reset is released, `tx_start` equals `nbr_present`.
- R2: `tx_start` equals `nbr_present` for exactly one clock at the start of each virtual cycle. It is zero in every other clock, including the enable clock.
- R3: `tgt_en` stays low until, within the current virtual cycle, three conditions hold: `tx_done` has been seen for every present direction, `rx_valid` has been seen for every present direction, and `mem_done` has been seen.
- R4: `tx_done` and `rx_valid` pulses on directions whose `nbr_present` bit is 0 are ignored. They are neither needed for the enable nor able to cause it.
- R5: If the last outstanding event is driven in clock k, `tgt_en` is low in clock k+1 and high in clock k+2. Events may arrive in any order and in any grouping.
- R6: `tgt_en` is high for exactly one clock. The clock after it starts the next virtual cycle, so `tx_start` equals `nbr_present` in that clock.
- R7: The enable clears all seen-event flags, so every condition must be met again in the next virtual cycle. An `rx_valid` that arrives during the enable clock belongs to the next virtual cycle and is kept for it.
- R8: `vcyc_count` rises by one in the clock after each enable and holds its value otherwise. It wraps modulo 2^CNT_W.
- R9: Direction bit i means the same neighbour on every per-direction port: bit 0 north, bit 1 east, bit 2 south, bit 3 west.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nbr_present | input | NDIR | Set bit: a neighbour exists in that direction |
| tx_start | output | NDIR | One-clock request to begin sending sync data per direction |
| tx_done | input | NDIR | One-clock pulse: the sender for that direction has finished |
| rx_valid | input | NDIR | One-clock pulse: sync data from that neighbour has arrived |
| mem_done | input | 1 | One-clock pulse: memory accesses for this virtual cycle are complete |
| tgt_en | output | 1 | Single-clock enable that advances all target flip-flops |
| vcyc_count | output | CNT_W | Number of completed virtual cycles, wrapping |

## Verification
The hardest situation to reach is a neighbour that is already one virtual cycle ahead, so that its data lands in the same clock as the local enable. In that case the clear and the new arrival must not cancel each other. The bench drives `rx_valid` exactly in the enable clock. It then supplies only the link-done and memory events in the next cycle and expects the enable on time. A following cycle withholds one present direction while pulsing every absent direction, to show that stale flags were cleared. These cases are swept over all sixteen presence masks, with simultaneous, staggered and withheld event orders. The counter width is kept small so that it wraps several times.

// File: rtl/vcb_pkg.sv
// Shared types for the virtual-cycle barrier controller.
// Assumes: one controller per tile, four mesh directions.
package vcb_pkg;

    // Controller phases within one virtual cycle
    typedef enum logic [1:0] {
        VC_IDLE = 2'd0,   // after reset, before the first cycle
        VC_SEND = 2'd1,   // request transmission on all present links
        VC_WAIT = 2'd2,   // collect done/arrival/memory events
        VC_FIRE = 2'd3    // target enable clock
    } vc_state_t;

    // Direction index shared by every per-direction bus
    localparam int DIR_NORTH = 0;
    localparam int DIR_EAST  = 1;
    localparam int DIR_SOUTH = 2;
    localparam int DIR_WEST  = 3;

endpackage

// File: rtl/vcb_flag_bank.sv
// Per-source event latch bank.
// Each bit is set by a one-clock event pulse and cleared by clr. An event
// in the same clock as clr survives, so it counts for the next round.
// all_met is high once every bit selected by need is set.
// Assumes: event pulses are at most one per bit per round.
module vcb_flag_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] ev,
    input  logic [W-1:0] need,
    output logic [W-1:0] flags,
    output logic         all_met
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            // Latch one source: clear on round end, then apply new event
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flags[i] <= 1'b0;
                end else begin
                    flags[i] <= (flags[i] & ~clr) | ev[i];
                end
            end
        end
    endgenerate

    // Sources that are not needed count as satisfied
    always_comb begin
        all_met = &(flags | ~need);
    end

endmodule

// File: rtl/vcb_fsm.sv
// Phase sequencer for the virtual cycle.
// IDLE -> SEND -> WAIT -> (ready) FIRE -> SEND ...
// Assumes: ready comes from registered flags, so a FIRE is one clock after
// the condition is first seen in WAIT.
module vcb_fsm
    import vcb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ready,
    output logic send,
    output logic fire
);

    vc_state_t state_q, state_d;

    // Next-phase selection
    always_comb begin
        state_d = state_q;
        case (state_q)
            VC_IDLE: state_d = VC_SEND;
            VC_SEND: state_d = VC_WAIT;
            VC_WAIT: if (ready) state_d = VC_FIRE;
            VC_FIRE: state_d = VC_SEND;
            default: state_d = VC_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= VC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Phase decode for the outputs
    always_comb begin
        send = (state_q == VC_SEND);
        fire = (state_q == VC_FIRE);
    end

endmodule

// File: rtl/vcb_counter.sv
// Wrapping counter of completed virtual cycles.
// Assumes: inc is a single-clock pulse per completed cycle.
module vcb_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    // Advance by one on each completion, wrapping at full scale
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/vcyc_barrier_ctrl.sv
// Virtual-cycle barrier controller (top).
// Starts each virtual cycle by requesting transmission on every present
// link. It waits for all present links to finish sending and to deliver
// neighbour data, and for the memory multiplexer to finish. It then issues
// a one-clock target enable.
// Assumes: nbr_present is quasi-static; event inputs are one-clock pulses.
module vcyc_barrier_ctrl #(
    parameter int NDIR  = 4,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NDIR-1:0]  nbr_present,
    output logic [NDIR-1:0]  tx_start,
    input  logic [NDIR-1:0]  tx_done,
    input  logic [NDIR-1:0]  rx_valid,
    input  logic             mem_done,
    output logic             tgt_en,
    output logic [CNT_W-1:0] vcyc_count
);

    logic            send;
    logic            fire;
    logic            ready;
    logic            tx_all;
    logic            rx_all;
    logic            mem_all;
    logic [NDIR-1:0] tx_flags;
    logic [NDIR-1:0] rx_flags;
    logic [0:0]      mem_flag;

    // Sender completion per direction
    vcb_flag_bank #(.W(NDIR)) u_tx_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (fire),
        .ev      (tx_done),
        .need    (nbr_present),
        .flags   (tx_flags),
        .all_met (tx_all)
    );

    // Neighbour data arrival per direction
    vcb_flag_bank #(.W(NDIR)) u_rx_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (fire),
        .ev      (rx_valid),
        .need    (nbr_present),
        .flags   (rx_flags),
        .all_met (rx_all)
    );

    // Memory multiplexer completion
    vcb_flag_bank #(.W(1)) u_mem_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (fire),
        .ev      (mem_done),
        .need    (1'b1),
        .flags   (mem_flag),
        .all_met (mem_all)
    );

    // Barrier condition: every input to the virtual cycle is in
    always_comb begin
        ready = tx_all & rx_all & mem_all;
    end

    vcb_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (ready),
        .send  (send),
        .fire  (fire)
    );

    vcb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (fire),
        .count (vcyc_count)
    );

    // Output drive: start requests only toward existing neighbours
    always_comb begin
        tx_start = nbr_present & {NDIR{send}};
        tgt_en   = fire;
    end

endmodule

// File: rtl/vcb_checker.sv
// Protocol checker for vcyc_barrier_ctrl, attached with bind.
// Assumes: observes ports only.
module vcb_checker #(
    parameter int NDIR  = 4,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NDIR-1:0]  nbr_present,
    input logic [NDIR-1:0]  tx_start,
    input logic             tgt_en,
    input logic [CNT_W-1:0] vcyc_count
);

    assert_en_one_clock_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_en |=> !tgt_en);

    assert_en_then_send_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_en |=> (tx_start == nbr_present));

    assert_start_one_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_start != '0) |=> (tx_start == '0));

    assert_no_start_in_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(tgt_en && (tx_start != '0)));

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_en |=> (vcyc_count == CNT_W'($past(vcyc_count) + 1'b1)));

    assert_count_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_en |=> $stable(vcyc_count));

endmodule

bind vcyc_barrier_ctrl vcb_checker #(.NDIR(NDIR), .CNT_W(CNT_W)) u_vcb_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .nbr_present (nbr_present),
    .tx_start    (tx_start),
    .tgt_en      (tgt_en),
    .vcyc_count  (vcyc_count)
);

// File: tb/vcyc_barrier_ctrl_tb.sv
`timescale 1ns/1ps
module vcyc_barrier_ctrl_tb;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    present = 4'h0;
    logic [3:0]    tx_start;
    logic [3:0]    txd = 4'h0;
    logic [3:0]    rxv = 4'h0;
    logic          memd = 1'b0;
    logic          tgt_en;
    logic [CW-1:0] cnt;

    int total = 0;
    int bad   = 0;
    int exp_cnt = 0;

    always #2.5 clk = ~clk;

    vcyc_barrier_ctrl #(.NDIR(4), .CNT_W(CW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .nbr_present (present),
        .tx_start    (tx_start),
        .tx_done     (txd),
        .rx_valid    (rxv),
        .mem_done    (memd),
        .tgt_en      (tgt_en),
        .vcyc_count  (cnt)
    );

    task automatic check(input int act, input int expv, input string req);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
        end
    endtask

    // One-clock event pulse; enable must still be low when it is driven
    task automatic pulse(input logic [3:0] t, input logic [3:0] r, input logic m);
        check(int'(tgt_en), 0, "R3 enable early");
        txd = t; rxv = r; memd = m;
        @(negedge clk);
        txd = 4'h0; rxv = 4'h0; memd = 1'b0;
    endtask

    // Expect enable two clocks after the last pulse, then the next cycle
    task automatic finish(input logic [3:0] next_mask, input logic carry_out);
        check(int'(tgt_en), 0, "R5 enable one clock after last event");
        check(int'(tx_start), 0, "R2 start idle while waiting");
        @(negedge clk);
        check(int'(tgt_en), 1, "R5 enable two clocks after last event");
        check(int'(tx_start), 0, "R2 start low in enable clock");
        present = next_mask;
        if (carry_out) rxv = 4'hF;          // R7 early arrival in enable clock
        @(negedge clk);
        rxv = 4'h0;
        check(int'(tgt_en), 0, "R6 enable lasts one clock");
        check(int'(tx_start), int'(next_mask), "R6 R9 start follows enable");
        exp_cnt = (exp_cnt + 1) % (1 << CW);
        check(int'(cnt), exp_cnt, "R8 cycle count");
    endtask

    // One virtual cycle starting at a negedge in the send phase
    task automatic run_vc(input logic [3:0] m, input int v, input logic carry_in,
                          input logic [3:0] next_mask, input logic carry_out);
        logic [3:0] rneed;
        logic [3:0] wh;
        rneed = carry_in ? 4'h0 : m;
        case (v)
            0: begin
                pulse(m, rneed, 1'b1);
            end
            1: begin
                for (int d = 0; d < 4; d++) if (m[d]) pulse(4'h1 << d, 4'h0, 1'b0);
                for (int d = 0; d < 4; d++) if (rneed[d]) pulse(4'h0, 4'h1 << d, 1'b0);
                pulse(4'h0, 4'h0, 1'b1);
            end
            default: begin
                // Withhold one present arrival (or memory when isolated); R4 R7
                wh = m & (~m + 4'h1);
                pulse(m | ~m, (rneed & ~wh) | ~m, (m != 4'h0));
                for (int i = 0; i < 4; i++) pulse(~m, ~m, 1'b0);
                if (m != 4'h0) pulse(4'h0, wh, 1'b0);
                else pulse(4'h0, 4'h0, 1'b1);
            end
        endcase
        finish(next_mask, carry_out);
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic carry;
        present = 4'h0;
        repeat (3) @(negedge clk);
        check(int'(tgt_en), 0, "R1 enable in reset");
        check(int'(tx_start), 0, "R1 start in reset");
        check(int'(cnt), 0, "R1 count in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(tx_start), 0, "R1 R9 first start with empty mask");
        carry = 1'b0;
        for (int m = 0; m < 16; m++) begin
            for (int v = 0; v < 4; v++) begin
                logic [3:0] nm;
                logic co;
                nm = (v == 3) ? 4'((m + 1) % 16) : 4'(m);
                co = (v == 3);
                run_vc(4'(m), (v == 3) ? 0 : v, carry, nm, co);
                carry = co;
            end
        end
        // Final cycle consumes the last carried arrival, then idle check R3
        run_vc(4'h0, 0, carry, 4'hF, 1'b0);
        pulse(4'hF, 4'h0, 1'b1);
        repeat (3) pulse(4'h0, 4'h0, 1'b0);
        check(int'(tgt_en), 0, "R3 R7 no enable without fresh arrivals");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule